// File: doc/BRIEF.md
# ADC Result FIFO with Block-Count DMA Request

This block collects conversion results from one ADC conversion group into a 64-entry result memory. Software and DMA see that memory as a first-in first-out queue, read through one fixed read port. Each stored word holds the conversion value. If configuration asks for it, the word also holds the ID of the channel that produced the value.

A signed 8-bit block counter sets when a DMA transfer should start. Software loads it with the number of results to collect. Each stored result steps it down by one, and each FIFO read steps it up by one. The block raises a single-cycle DMA request only when a store moves the counter from 1 to 0. Hardware never reloads the counter. If stores keep arriving before any reads, the counter goes negative, and software must write a new value before another request can happen.

When the memory is full, the next result is dropped and an overflow flag is set. Every later result is also dropped until software clears the flag through the configuration write port.

Top module: `adc_result_fifo`

## Requirements
- R1: After reset the block count is 0, the fill level is 0, `rd_empty` is 1, and `overflow` and `dma_req` are 0.
- R2: Accepted results come out of `rd_data` in arrival order. `rd_data` always shows the oldest stored word, and a read (`rd_en` with the FIFO not empty) removes it at the clock edge. Each accepted store raises `fill_level` by one and each read lowers it by one.
- R3: A result that arrives while 64 entries are held is dropped, and `overflow` is set on the next cycle. While `overflow` is set, every result is dropped, even if there is free space. A configuration write with `cfg_ovr_clr` = 1 clears the flag. The entries already stored stay intact.
- R4: Each accepted store decrements `blk_count` by one, and each read of a non-empty FIFO increments it by one. Dropped results do not change it.
- R5: When `dma_en` is set, `dma_req` is high for exactly one cycle. That cycle is the one in which `blk_count` first shows 0 after an accepted store moved it from 1. No other change of the counter raises it, including a read that moves it from -1 to 0.
- R6: Hardware never reloads the counter after a request. Further stores take it below zero, and no request follows until software writes a new value.
- R7: An accepted store and a read in the same cycle leave both `blk_count` and `fill_level` unchanged.
- R8: When the FIFO is empty, `rd_data` is 0 and `rd_empty` is 1. Asserting `rd_en` in that state changes neither the counter nor the fill level.
- R9: When `chid_en` is set, each stored word carries `res_chid` in bits [16:12] and the value in bits [11:0]. When it is clear, bits [16:12] are stored as 0. The setting that applies is the one in force when the result is stored.
- R10: The counter saturates at its limits. A store at -128 leaves it at -128, and a read at +127 leaves it at +127.
- R11: `cfg_we` loads `cfg_blocks` into the counter, taking priority over any same-cycle store or read step, and it never raises a request. It also loads the DMA-enable and channel-ID-enable bits. A store in the same cycle is still placed in the FIFO.
- R12: While the DMA-enable bit is 0, a 1-to-0 step of the counter produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_vld | input | 1 | Conversion result strobe |
| res_data | input | 12 | Conversion value |
| res_chid | input | 5 | Channel ID of the result |
| rd_en | input | 1 | FIFO read strobe (fixed read port) |
| rd_data | output | 17 | Oldest stored word, 0 when empty |
| rd_empty | output | 1 | FIFO holds no entries |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_blocks | input | 8 | Block count to load (two's complement) |
| cfg_dma_en | input | 1 | DMA-enable bit to load |
| cfg_chid_en | input | 1 | Channel-ID-enable bit to load |
| cfg_ovr_clr | input | 1 | Clear the overflow flag on this write |
| blk_count | output | 8 | Current block count (two's complement) |
| fill_level | output | 7 | Number of stored entries |
| overflow | output | 1 | Overflow flag |
| dma_req | output | 1 | Single-cycle DMA request |

## Verification
The hardest states to reach are the counter extremes. Without reads, stores alone can lower the count by at most 64, so the bench preloads -100 and then stores 40 results to hold the counter at -128. It reaches +127 by loading that value with data queued and then reading. The overflow path needs exactly 64 held entries followed by one more result. The bench then shows that results stay dropped after a read has freed space. A long pseudo-random sweep mixes stores, reads, simultaneous store and read, and occasional reconfiguration, and it compares every output each cycle against an arithmetic queue and counter model.

// File: rtl/adcf_pkg.sv
`timescale 1ns/1ps
package adcf_pkg;
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_DOWN = 2'd1,
        STEP_UP   = 2'd2,
        STEP_LOAD = 2'd3
    } cnt_step_e;
endpackage

// File: rtl/adcf_mem.sv
`timescale 1ns/1ps
module adcf_mem #(
    parameter int DEPTH  = 64,
    parameter int WORD_W = 17,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/adcf_ctrl.sv
`timescale 1ns/1ps
module adcf_ctrl #(
    parameter int DEPTH  = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     res_vld,
    input  logic                     rd_en,
    input  logic                     cfg_we,
    input  logic                     cfg_dma_en,
    input  logic                     cfg_chid_en,
    input  logic                     cfg_ovr_clr,
    output logic                     store_acc,
    output logic                     rd_fire,
    output logic [PTR_W-1:0]         wr_ptr,
    output logic [PTR_W-1:0]         rd_ptr,
    output logic [LVL_W-1:0]         level,
    output logic                     ovf,
    output logic                     dma_en,
    output logic                     chid_en,
    output adcf_pkg::cnt_step_e      step
);
    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [LVL_W-1:0] level;
        logic             ovf;
        logic             dma_en;
        logic             chid_en;
    } ctrl_s;

    ctrl_s q, d;
    logic  full;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        d         = q;
        full      = (q.level == LVL_W'(DEPTH));
        rd_fire   = rd_en && (q.level != '0);
        store_acc = res_vld && !q.ovf && !full;
        if (store_acc) d.wr_ptr = ptr_inc(q.wr_ptr);
        if (rd_fire)   d.rd_ptr = ptr_inc(q.rd_ptr);
        case ({store_acc, rd_fire})
            2'b10:   d.level = q.level + LVL_W'(1);
            2'b01:   d.level = q.level - LVL_W'(1);
            default: d.level = q.level;
        endcase
        if (cfg_we && cfg_ovr_clr)  d.ovf = 1'b0;
        else if (res_vld && full)   d.ovf = 1'b1;
        if (cfg_we) begin
            d.dma_en  = cfg_dma_en;
            d.chid_en = cfg_chid_en;
        end
        if (cfg_we)                      step = adcf_pkg::STEP_LOAD;
        else if (store_acc && !rd_fire)  step = adcf_pkg::STEP_DOWN;
        else if (rd_fire && !store_acc)  step = adcf_pkg::STEP_UP;
        else                             step = adcf_pkg::STEP_HOLD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wr_ptr  = q.wr_ptr;
    assign rd_ptr  = q.rd_ptr;
    assign level   = q.level;
    assign ovf     = q.ovf;
    assign dma_en  = q.dma_en;
    assign chid_en = q.chid_en;
endmodule

// File: rtl/adcf_blkcnt.sv
`timescale 1ns/1ps
module adcf_blkcnt #(
    parameter int CNT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  adcf_pkg::cnt_step_e step,
    input  logic [CNT_W-1:0]    load_val,
    input  logic                dma_en,
    output logic [CNT_W-1:0]    count,
    output logic                dma_req
);
    localparam logic [CNT_W-1:0] CNT_MIN = {1'b1, {(CNT_W-1){1'b0}}};
    localparam logic [CNT_W-1:0] CNT_MAX = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             req;
    } blk_s;

    blk_s q, d;

    always_comb begin
        d     = q;
        d.req = 1'b0;
        case (step)
            adcf_pkg::STEP_LOAD: d.cnt = load_val;
            adcf_pkg::STEP_DOWN: begin
                if (q.cnt != CNT_MIN) d.cnt = q.cnt - CNT_ONE;
                d.req = dma_en && (q.cnt == CNT_ONE);
            end
            adcf_pkg::STEP_UP: begin
                if (q.cnt != CNT_MAX) d.cnt = q.cnt + CNT_ONE;
            end
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign count   = q.cnt;
    assign dma_req = q.req;
endmodule

// File: rtl/adc_result_fifo.sv
`timescale 1ns/1ps
module adc_result_fifo #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 12,
    parameter int CHID_W = 5,
    parameter int CNT_W  = 8,
    localparam int WORD_W = DATA_W + CHID_W,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_vld,
    input  logic [DATA_W-1:0] res_data,
    input  logic [CHID_W-1:0] res_chid,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_empty,
    input  logic              cfg_we,
    input  logic [CNT_W-1:0]  cfg_blocks,
    input  logic              cfg_dma_en,
    input  logic              cfg_chid_en,
    input  logic              cfg_ovr_clr,
    output logic [CNT_W-1:0]  blk_count,
    output logic [LVL_W-1:0]  fill_level,
    output logic              overflow,
    output logic              dma_req
);
    logic                store_acc, rd_fire, dma_en, chid_en;
    logic [PTR_W-1:0]    wr_ptr, rd_ptr;
    logic [WORD_W-1:0]   wdata, mem_rdata;
    adcf_pkg::cnt_step_e step;

    adcf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .res_vld(res_vld), .rd_en(rd_en),
        .cfg_we(cfg_we), .cfg_dma_en(cfg_dma_en), .cfg_chid_en(cfg_chid_en),
        .cfg_ovr_clr(cfg_ovr_clr), .store_acc(store_acc), .rd_fire(rd_fire),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .level(fill_level), .ovf(overflow),
        .dma_en(dma_en), .chid_en(chid_en), .step(step)
    );

    assign wdata = {(chid_en ? res_chid : {CHID_W{1'b0}}), res_data};

    adcf_mem #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_mem (
        .clk(clk), .we(store_acc), .waddr(wr_ptr), .wdata(wdata),
        .raddr(rd_ptr), .rdata(mem_rdata)
    );

    adcf_blkcnt #(.CNT_W(CNT_W)) u_blk (
        .clk(clk), .rst_n(rst_n), .step(step), .load_val(cfg_blocks),
        .dma_en(dma_en), .count(blk_count), .dma_req(dma_req)
    );

    assign rd_empty = (fill_level == '0);
    assign rd_data  = rd_empty ? '0 : mem_rdata;
endmodule

// File: rtl/adc_result_fifo_chk.sv
`timescale 1ns/1ps
module adc_result_fifo_chk #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             res_vld,
    input logic             rd_en,
    input logic             rd_empty,
    input logic             cfg_we,
    input logic [CNT_W-1:0] blk_count,
    input logic [LVL_W-1:0] fill_level,
    input logic             overflow,
    input logic             dma_req
);
    a_r5_req_on_one_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (blk_count == '0 && $past(blk_count) == CNT_W'(1)));

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |=> !dma_req);

    a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= LVL_W'(DEPTH));

    a_r3_drop_while_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !rd_en) |=> fill_level == $past(fill_level));

    a_r8_empty_read_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_empty && rd_en && !res_vld && !cfg_we) |=> ($stable(blk_count) && $stable(fill_level)));

    a_r7_store_and_read: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && rd_en && !rd_empty && !overflow && fill_level < LVL_W'(DEPTH) && !cfg_we)
        |=> ($stable(blk_count) && $stable(fill_level)));
endmodule

bind adc_result_fifo adc_result_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .res_vld(res_vld), .rd_en(rd_en), .rd_empty(rd_empty),
    .cfg_we(cfg_we), .blk_count(blk_count), .fill_level(fill_level),
    .overflow(overflow), .dma_req(dma_req)
);

// File: tb/adc_result_fifo_bench.sv
`timescale 1ns/1ps
module adc_result_fifo_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_vld = 1'b0;
    logic [11:0] res_data = '0;
    logic [4:0]  res_chid = '0;
    logic        rd_en = 1'b0;
    logic [16:0] rd_data;
    logic        rd_empty;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_blocks = '0;
    logic        cfg_dma_en = 1'b0;
    logic        cfg_chid_en = 1'b0;
    logic        cfg_ovr_clr = 1'b0;
    logic [7:0]  blk_count;
    logic [6:0]  fill_level;
    logic        overflow;
    logic        dma_req;

    always #10 clk = ~clk;

    adc_result_fifo u_adc_result_fifo (
        .clk(clk), .rst_n(rst_n), .res_vld(res_vld), .res_data(res_data),
        .res_chid(res_chid), .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty),
        .cfg_we(cfg_we), .cfg_blocks(cfg_blocks), .cfg_dma_en(cfg_dma_en),
        .cfg_chid_en(cfg_chid_en), .cfg_ovr_clr(cfg_ovr_clr), .blk_count(blk_count),
        .fill_level(fill_level), .overflow(overflow), .dma_req(dma_req)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // reference model
    logic [16:0] mq[$];
    int  m_cnt = 0;
    bit  m_ovf = 0, m_den = 0, m_cen = 0;
    int  req_seen = 0;

    task automatic chk(input string tag, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic step(input bit sv, input logic [11:0] d, input logic [4:0] ch,
                        input bit rv, input bit cw, input logic [7:0] cb,
                        input bit cde, input bit cce, input bit cclr);
        bit full, rdf, st, exp_req;
        res_vld = sv; res_data = d; res_chid = ch; rd_en = rv;
        cfg_we = cw; cfg_blocks = cb; cfg_dma_en = cde; cfg_chid_en = cce; cfg_ovr_clr = cclr;
        #1;
        if (mq.size() == 0) begin
            chk("R8 empty rd_data", int'(rd_data), 0);
            chk("R8 empty flag", int'(rd_empty), 1);
        end else begin
            chk("R2 head rd_data", int'(rd_data), int'(mq[0]));
        end
        full = (mq.size() == 64);
        rdf = rv && (mq.size() > 0);
        st = sv && !m_ovf && !full;
        exp_req = 0;
        if (cw) m_cnt = int'($signed(cb));
        else if (st && !rdf) begin
            exp_req = m_den && (m_cnt == 1);
            if (m_cnt > -128) m_cnt--;
        end else if (rdf && !st) begin
            if (m_cnt < 127) m_cnt++;
        end
        if (rdf) void'(mq.pop_front());
        if (st) mq.push_back({(m_cen ? ch : 5'd0), d});
        if (cw && cclr) m_ovf = 0;
        else if (sv && full) m_ovf = 1;
        if (cw) begin m_den = cde; m_cen = cce; end
        @(posedge clk); #1;
        res_vld = 0; rd_en = 0; cfg_we = 0; cfg_ovr_clr = 0;
        chk("R4 blk_count", int'($signed(blk_count)), m_cnt);
        chk("R2 fill_level", int'(fill_level), mq.size());
        chk("R3 overflow", int'(overflow), int'(m_ovf));
        chk("R5 dma_req", int'(dma_req), int'(exp_req));
        if (dma_req) req_seen++;
    endtask

    task automatic store(input logic [11:0] d, input logic [4:0] ch);
        step(1, d, ch, 0, 0, 8'd0, 0, 0, 0);
    endtask
    task automatic rd();
        step(0, 12'd0, 5'd0, 1, 0, 8'd0, 0, 0, 0);
    endtask
    task automatic cfg(input logic [7:0] b, input bit de, input bit ce, input bit clr);
        step(0, 12'd0, 5'd0, 0, 1, b, de, ce, clr);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int r0, r1, l0;
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1 count", int'(blk_count), 0);
        chk("R1 level", int'(fill_level), 0);
        chk("R1 empty", int'(rd_empty), 1);
        chk("R1 overflow", int'(overflow), 0);
        chk("R1 dma_req", int'(dma_req), 0);

        // R9 channel ID field and R5 request on fourth store
        cfg(8'd4, 1, 1, 0);
        r0 = req_seen;
        for (int i = 0; i < 4; i++) store(12'(100 + i), 5'(21 + i));
        chk("R5 one request after four stores", req_seen - r0, 1);
        chk("R9 chid in bits 16:12", int'(rd_data[16:12]), 21);
        chk("R9 value in bits 11:0", int'(rd_data[11:0]), 100);

        // R6 no reload: counter goes negative, no further request
        r0 = req_seen;
        for (int i = 0; i < 3; i++) store(12'(200 + i), 5'd3);
        chk("R6 negative count", int'($signed(blk_count)), -3);
        for (int i = 0; i < 3; i++) rd();
        chk("R6 no request going negative or back to zero", req_seen - r0, 0);

        // R7 simultaneous store and read
        r1 = int'($signed(blk_count)); l0 = fill_level;
        step(1, 12'hABC, 5'd7, 1, 0, 8'd0, 0, 0, 0);
        chk("R7 count unchanged", int'($signed(blk_count)), r1);
        chk("R7 level unchanged", int'(fill_level), l0);

        // R8 empty read
        while (mq.size() > 0) rd();
        r1 = int'($signed(blk_count));
        rd();
        chk("R8 empty read count unchanged", int'($signed(blk_count)), r1);

        // R12 request suppressed when DMA disabled; chid disabled stores zero ID
        cfg(8'd1, 0, 0, 0);
        r0 = req_seen;
        store(12'h055, 5'd31);
        chk("R12 no request when disabled", req_seen - r0, 0);
        chk("R9 chid zero when disabled", int'(rd_data[16:12]), 0);
        rd();

        // R3 overflow
        cfg(8'd0, 1, 1, 0);
        for (int i = 0; i < 64; i++) store(12'(i), 5'(i));
        chk("R3 full no overflow yet", int'(overflow), 0);
        store(12'hFFF, 5'd1);
        chk("R3 overflow set", int'(overflow), 1);
        chk("R3 level held at 64", int'(fill_level), 64);
        rd();
        store(12'hEEE, 5'd2);
        chk("R3 dropped with free space", int'(fill_level), 63);
        cfg(8'd0, 1, 1, 1);
        chk("R3 overflow cleared", int'(overflow), 0);
        store(12'h321, 5'd9);
        chk("R3 store after clear", int'(fill_level), 64);
        while (mq.size() > 0) rd();

        // R10 saturation
        cfg(8'h9C, 1, 0, 0);          // -100
        for (int i = 0; i < 40; i++) store(12'(i), 5'd0);
        chk("R10 saturate low", int'($signed(blk_count)), -128);
        cfg(8'h7F, 1, 0, 0);
        rd();
        chk("R10 saturate high", int'($signed(blk_count)), 127);
        while (mq.size() > 0) rd();

        // R11 config write beats same-cycle store
        step(1, 12'h777, 5'd4, 0, 1, 8'd5, 1, 1, 0);
        chk("R11 loaded value wins", int'($signed(blk_count)), 5);
        chk("R11 store still queued", int'(fill_level), 1);
        rd();

        // pseudo-random sweep
        lfsr = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3:0] == 4'hF)
                step(lfsr[4], 12'(lfsr), 5'(lfsr >> 5), lfsr[5], 1,
                     8'($signed(lfsr[10:7]) + 2), lfsr[11], lfsr[12], lfsr[13]);
            else
                step(lfsr[4] | lfsr[6], 12'(lfsr ^ 16'(i)), 5'(lfsr >> 7),
                     lfsr[5] & (lfsr[8] | lfsr[9]), 0, 8'd0, 0, 0, 0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule